// File: doc/BRIEF.md
# Two-Step MLC Program Controller with Clean LSB Copy

This controller drives the two programming steps of a multi-level-cell flash wordline. The first step loads the low page into the chip's internal low-page buffer and programs it. The second step loads the high page and programs the cell to its final level. While the cell waits between the two steps it holds the low page only in a partially programmed state. Neighbouring writes and reads can corrupt that state. For this reason the controller never lets the chip fetch the low page back from its own cells. During the first step it places a copy of every low page in a controller-side store, tagged with the wordline address.

When a high-page command arrives, the controller looks the wordline up in its tag table. On a hit it streams the stored low page into the chip's low-page buffer. On a miss it issues a low-page read and passes the raw beats to an external error-correction engine. The corrected beats are written into a store slot and then streamed to the chip. Only after that does the controller stream the high page from the host and issue the high-page program. If the correction engine reports the page as uncorrectable, the command is abandoned before any load and an error flag is raised. The entry for a wordline is dropped once its high page has completed. A store-loss input drops every entry at once.

All data moves in beats of `BEAT_W` bits under valid/ready handshakes, `PAGE_BEATS` beats per page. The slot storage is external and is reached through a slot/beat addressed port with a combinational read.

Top module: `lsb_cache_prog_ctrl`

## Requirements
- R1: After reset, `busy` is 0, `cmd_ready` is 1, `fl_valid` is 0 and `prog_err` is 0. A command is accepted only when `cmd_valid` and `cmd_ready` are both high, and `busy` is then high in the following cycle and stays high until the operation ends.
- R2: A low-page command (`cmd_msb`=0) sends `PAGE_BEATS` host beats to the flash with `fl_op`=0 (load low). Each beat carries the host data and `fl_wl` equal to the command's wordline, and `fl_last` is set on the final beat only. Each beat is also written to the store (`st_we`) at the beat index. A single `fl_op`=2 (program low) follows, and `busy` falls one cycle after `fl_done`.
- R3: A high-page command that hits sends `PAGE_BEATS` beats with `fl_op`=0 carrying the stored low page, then `PAGE_BEATS` host beats with `fl_op`=1 (load high), then a single `fl_op`=3 (program high). It issues no read.
- R4: A high-page command that misses first issues `fl_op`=4 (read low). It forwards `PAGE_BEATS` flash read beats to the correction engine, with `ecc_in_last` on the final beat. It writes the corrected beats to the store, then continues exactly as in R3 using the corrected data.
- R5: If `ecc_out_bad` is high on the final corrected beat, no load or program follows. In that case `busy` is 0 and `prog_err` is 1 in the next cycle. `prog_err` returns to 0 when the next command is accepted.
- R6: A pulse on `buf_lost` drops every stored entry, so the next high-page command for any wordline takes the miss path of R4.
- R7: After a high-page program completes, the entry for that wordline is dropped: a second high-page command to the same wordline misses.
- R8: A low-page command takes the slot already holding its wordline, else the lowest free slot, else a round-robin victim starting at slot 0. No wordline is ever held in two valid slots.
- R9: While `fl_valid` is high and `fl_ready` is low, `fl_valid`, `fl_op` and `fl_wl` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Controller idle, command accepted |
| cmd_msb | input | 1 | 0 = low-page step, 1 = high-page step |
| cmd_wl | input | WL_W | Wordline address |
| hd_valid | input | 1 | Host page beat valid |
| hd_ready | output | 1 | Host page beat taken |
| hd_data | input | BEAT_W | Host page beat |
| fl_valid | output | 1 | Flash beat/command valid |
| fl_ready | input | 1 | Flash accepts beat/command |
| fl_op | output | 3 | 0 load low, 1 load high, 2 program low, 3 program high, 4 read low |
| fl_wl | output | WL_W | Wordline of the operation |
| fl_data | output | BEAT_W | Load beat data |
| fl_last | output | 1 | Final load beat of a page |
| fl_done | input | 1 | Program completion pulse |
| rd_valid | input | 1 | Raw read beat valid |
| rd_ready | output | 1 | Raw read beat taken |
| rd_data | input | BEAT_W | Raw read beat |
| ecc_in_valid | output | 1 | Beat to correction engine valid |
| ecc_in_ready | input | 1 | Correction engine takes beat |
| ecc_in_data | output | BEAT_W | Raw beat to correction engine |
| ecc_in_last | output | 1 | Final raw beat |
| ecc_out_valid | input | 1 | Corrected beat valid |
| ecc_out_ready | output | 1 | Corrected beat taken |
| ecc_out_data | input | BEAT_W | Corrected beat |
| ecc_out_bad | input | 1 | Page uncorrectable, qualified on final beat |
| st_we | output | 1 | Store write strobe |
| st_slot | output | SLOT_W | Store slot for read and write |
| st_beat | output | BEAT_IW | Store beat index |
| st_wdata | output | BEAT_W | Store write data |
| st_rdata | input | BEAT_W | Store read data, combinational from slot/beat |
| buf_lost | input | 1 | Store contents lost |
| busy | output | 1 | Operation in progress |
| prog_err | output | 1 | Last high-page step aborted |

## Verification
The assertions watch, on every cycle, four properties: a held flash request keeps its opcode and wordline, an accepted command raises busy, an uncorrectable page ends the operation with the flag set, and a high-page program is never issued before a full high page has been loaded. In the tag table they also watch that a wordline never sits in two valid slots and that a loss pulse empties the table. The ordering and contents of the beat streams can only be shown by the bench's scenarios. These cover the stored low page reaching the chip on a hit, the corrected page on a miss, the drop after completion, the drop on loss, and which slot a victim takes.

// File: rtl/lsbc_pkg.sv
// Shared types for the two-step program controller.
// Assumes: fl_op encoding is decoded by the flash interface downstream.
package lsbc_pkg;

    typedef enum logic [2:0] {
        OP_LOAD_LSB = 3'd0,
        OP_LOAD_MSB = 3'd1,
        OP_PROG_LSB = 3'd2,
        OP_PROG_MSB = 3'd3,
        OP_READ_LSB = 3'd4
    } fl_op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_LDAT,
        S_LPROG,
        S_RCMD,
        S_RFEED,
        S_RFIX,
        S_MLSB,
        S_MMSB,
        S_MPROG,
        S_WAIT
    } seq_state_e;

endpackage

// File: rtl/lsbc_tag_table.sv
// Tag/valid table for the low-page copy slots.
// Looks up a wordline, proposes a slot (hit, lowest free, or round-robin
// victim) and updates entries on set/clear/flush requests.
// Assumes: SLOTS >= 2; flush wins over set and clear in the same cycle.
module lsbc_tag_table #(
    parameter int SLOTS = 4,
    parameter int WL_W  = 8,
    parameter int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WL_W-1:0]   look_wl,
    output logic              hit,
    output logic [SLOT_W-1:0] hit_slot,
    output logic [SLOT_W-1:0] alloc_slot,
    input  logic              claim,
    input  logic              set_en,
    input  logic [SLOT_W-1:0] set_slot,
    input  logic [WL_W-1:0]   set_wl,
    input  logic              clr_en,
    input  logic [SLOT_W-1:0] clr_slot,
    input  logic              flush
);

    logic [WL_W-1:0]   tag_q [SLOTS];
    logic [SLOTS-1:0]  vld_q;
    logic [SLOTS-1:0]  match;
    logic [SLOT_W-1:0] rr_q;
    logic [SLOT_W-1:0] free_slot;
    logic              any_free;

    // per-slot tag compare
    for (genvar g = 0; g < SLOTS; g++) begin : g_match
        assign match[g] = vld_q[g] && (tag_q[g] == look_wl);
    end

    // priority encode hit and lowest free slot
    always_comb begin
        hit       = |match;
        any_free  = ~&vld_q;
        hit_slot  = '0;
        free_slot = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (match[i]) hit_slot = SLOT_W'(i);
            if (!vld_q[i]) free_slot = SLOT_W'(i);
        end
        alloc_slot = hit ? hit_slot : (any_free ? free_slot : rr_q);
    end

    // entry state: flush, then set, then clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < SLOTS; i++) tag_q[i] <= '0;
        end else if (flush) begin
            vld_q <= '0;
        end else begin
            for (int i = 0; i < SLOTS; i++) begin
                if (set_en && set_slot == SLOT_W'(i)) begin
                    vld_q[i] <= 1'b1;
                    tag_q[i] <= set_wl;
                end else if (clr_en && clr_slot == SLOT_W'(i)) begin
                    vld_q[i] <= 1'b0;
                end
            end
        end
    end

    // victim pointer moves only when a full table is claimed
    always_ff @(posedge clk) begin
        if (!rst_n) rr_q <= '0;
        else if (claim && !hit && !any_free)
            rr_q <= (rr_q == SLOT_W'(SLOTS - 1)) ? '0 : rr_q + 1'b1;
    end

    assert_unique_tag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    assert_flush_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (vld_q == '0));

endmodule

// File: rtl/lsbc_seq.sv
// Operation sequencer: runs the low-page step, the high-page step with a
// stored or corrected low page, and the read/correct refill path.
// Assumes: the store read is combinational; the correction engine takes
// the whole raw page before returning corrected beats; the host holds
// hd_valid/hd_data until taken.
module lsbc_seq
    import lsbc_pkg::*;
#(
    parameter int WL_W       = 8,
    parameter int BEAT_W     = 32,
    parameter int PAGE_BEATS = 16,
    parameter int SLOT_W     = 2,
    parameter int BEAT_IW    = $clog2(PAGE_BEATS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic               cmd_msb,
    input  logic [WL_W-1:0]    cmd_wl,
    input  logic               hd_valid,
    output logic               hd_ready,
    input  logic [BEAT_W-1:0]  hd_data,
    output logic               fl_valid,
    input  logic               fl_ready,
    output logic [2:0]         fl_op,
    output logic [WL_W-1:0]    fl_wl,
    output logic [BEAT_W-1:0]  fl_data,
    output logic               fl_last,
    input  logic               fl_done,
    input  logic               rd_valid,
    output logic               rd_ready,
    input  logic [BEAT_W-1:0]  rd_data,
    output logic               ecc_in_valid,
    input  logic               ecc_in_ready,
    output logic [BEAT_W-1:0]  ecc_in_data,
    output logic               ecc_in_last,
    input  logic               ecc_out_valid,
    output logic               ecc_out_ready,
    input  logic [BEAT_W-1:0]  ecc_out_data,
    input  logic               ecc_out_bad,
    output logic               st_we,
    output logic [SLOT_W-1:0]  st_slot,
    output logic [BEAT_IW-1:0] st_beat,
    output logic [BEAT_W-1:0]  st_wdata,
    input  logic [BEAT_W-1:0]  st_rdata,
    output logic               busy,
    output logic               prog_err,
    input  logic               tag_hit,
    input  logic [SLOT_W-1:0]  tag_hit_slot,
    input  logic [SLOT_W-1:0]  tag_alloc_slot,
    output logic               tag_claim,
    output logic               tag_set,
    output logic               tag_clr
);

    localparam logic [BEAT_IW-1:0] LAST_BEAT = BEAT_IW'(PAGE_BEATS - 1);

    seq_state_e         state_q;
    logic [WL_W-1:0]    wl_q;
    logic [SLOT_W-1:0]  slot_q;
    logic [BEAT_IW-1:0] beat_q;
    logic               msb_q;
    logic               err_q;
    logic               msb_loaded_q;
    logic               last_beat;
    logic               accept;
    logic               fl_fire;
    fl_op_e             op;

    assign last_beat = (beat_q == LAST_BEAT);
    assign accept    = cmd_valid && (state_q == S_IDLE);
    assign fl_fire   = fl_valid && fl_ready;

    // handshake and datapath steering for the current state
    always_comb begin
        op            = OP_LOAD_LSB;
        fl_valid      = 1'b0;
        fl_data       = '0;
        hd_ready      = 1'b0;
        st_we         = 1'b0;
        st_wdata      = ecc_out_data;
        rd_ready      = 1'b0;
        ecc_in_valid  = 1'b0;
        ecc_out_ready = 1'b0;
        unique case (state_q)
            S_LDAT: begin
                op = OP_LOAD_LSB; fl_valid = hd_valid; fl_data = hd_data;
                hd_ready = fl_ready; st_we = hd_valid && fl_ready; st_wdata = hd_data;
            end
            S_LPROG: begin op = OP_PROG_LSB; fl_valid = 1'b1; end
            S_RCMD:  begin op = OP_READ_LSB; fl_valid = 1'b1; end
            S_RFEED: begin rd_ready = ecc_in_ready; ecc_in_valid = rd_valid; end
            S_RFIX:  begin ecc_out_ready = 1'b1; st_we = ecc_out_valid; end
            S_MLSB:  begin op = OP_LOAD_LSB; fl_valid = 1'b1; fl_data = st_rdata; end
            S_MMSB: begin
                op = OP_LOAD_MSB; fl_valid = hd_valid; fl_data = hd_data;
                hd_ready = fl_ready;
            end
            S_MPROG: begin op = OP_PROG_MSB; fl_valid = 1'b1; end
            default: ;
        endcase
    end

    assign fl_op       = op;
    assign fl_wl       = wl_q;
    assign fl_last     = last_beat && (state_q == S_LDAT || state_q == S_MLSB || state_q == S_MMSB);
    assign ecc_in_data = rd_data;
    assign ecc_in_last = (state_q == S_RFEED) && last_beat;
    assign st_slot     = slot_q;
    assign st_beat     = beat_q;
    assign busy        = (state_q != S_IDLE);
    assign cmd_ready   = (state_q == S_IDLE);
    assign prog_err    = err_q;

    // tag table requests: claim/clear on accept, set when a page is stored
    assign tag_claim = accept && !(cmd_msb && tag_hit);
    assign tag_set   = (state_q == S_LDAT && hd_valid && fl_ready && last_beat) ||
                       (state_q == S_RFIX && ecc_out_valid && last_beat && !ecc_out_bad);
    assign tag_clr   = tag_claim || (state_q == S_WAIT && fl_done && msb_q);

    // state, beat counter and captured command fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            wl_q    <= '0;
            slot_q  <= '0;
            beat_q  <= '0;
            msb_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: if (cmd_valid) begin
                    wl_q   <= cmd_wl;
                    msb_q  <= cmd_msb;
                    beat_q <= '0;
                    err_q  <= 1'b0;
                    if (!cmd_msb) begin
                        slot_q <= tag_alloc_slot; state_q <= S_LDAT;
                    end else if (tag_hit) begin
                        slot_q <= tag_hit_slot;   state_q <= S_MLSB;
                    end else begin
                        slot_q <= tag_alloc_slot; state_q <= S_RCMD;
                    end
                end
                S_LDAT: if (hd_valid && fl_ready) begin
                    beat_q <= last_beat ? '0 : beat_q + 1'b1;
                    if (last_beat) state_q <= S_LPROG;
                end
                S_LPROG: if (fl_ready) state_q <= S_WAIT;
                S_RCMD:  if (fl_ready) state_q <= S_RFEED;
                S_RFEED: if (rd_valid && ecc_in_ready) begin
                    beat_q <= last_beat ? '0 : beat_q + 1'b1;
                    if (last_beat) state_q <= S_RFIX;
                end
                S_RFIX: if (ecc_out_valid) begin
                    beat_q <= last_beat ? '0 : beat_q + 1'b1;
                    if (last_beat) begin
                        if (ecc_out_bad) begin
                            err_q <= 1'b1; state_q <= S_IDLE;
                        end else begin
                            state_q <= S_MLSB;
                        end
                    end
                end
                S_MLSB: if (fl_ready) begin
                    beat_q <= last_beat ? '0 : beat_q + 1'b1;
                    if (last_beat) state_q <= S_MMSB;
                end
                S_MMSB: if (hd_valid && fl_ready) begin
                    beat_q <= last_beat ? '0 : beat_q + 1'b1;
                    if (last_beat) state_q <= S_MPROG;
                end
                S_MPROG: if (fl_ready) state_q <= S_WAIT;
                S_WAIT:  if (fl_done) state_q <= S_IDLE;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // tracks that a full high page went out before its program command
    always_ff @(posedge clk) begin
        if (!rst_n || state_q == S_IDLE) msb_loaded_q <= 1'b0;
        else if (fl_fire && fl_op == OP_LOAD_MSB && fl_last) msb_loaded_q <= 1'b1;
    end

    assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> busy);

    assert_fl_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_valid && !fl_ready && state_q != S_LDAT && state_q != S_MMSB)
            |=> (fl_valid && $stable(fl_op) && $stable(fl_wl)));

    assert_abort_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ecc_out_valid && ecc_out_ready && last_beat && ecc_out_bad)
            |=> (!busy && prog_err));

    assert_msb_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_valid && fl_op == OP_PROG_MSB) |-> msb_loaded_q);

endmodule

// File: rtl/lsb_cache_prog_ctrl.sv
// Top: two-step wordline program controller keeping a clean low-page copy.
// Joins the tag table and the sequencer; slot data lives in an external
// store addressed by slot and beat.
// Assumes: PAGE_BEATS >= 2, SLOTS >= 2.
module lsb_cache_prog_ctrl #(
    parameter int WL_W       = 8,
    parameter int BEAT_W     = 32,
    parameter int PAGE_BEATS = 16,
    parameter int SLOTS      = 4,
    parameter int SLOT_W     = $clog2(SLOTS),
    parameter int BEAT_IW    = $clog2(PAGE_BEATS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic               cmd_msb,
    input  logic [WL_W-1:0]    cmd_wl,
    input  logic               hd_valid,
    output logic               hd_ready,
    input  logic [BEAT_W-1:0]  hd_data,
    output logic               fl_valid,
    input  logic               fl_ready,
    output logic [2:0]         fl_op,
    output logic [WL_W-1:0]    fl_wl,
    output logic [BEAT_W-1:0]  fl_data,
    output logic               fl_last,
    input  logic               fl_done,
    input  logic               rd_valid,
    output logic               rd_ready,
    input  logic [BEAT_W-1:0]  rd_data,
    output logic               ecc_in_valid,
    input  logic               ecc_in_ready,
    output logic [BEAT_W-1:0]  ecc_in_data,
    output logic               ecc_in_last,
    input  logic               ecc_out_valid,
    output logic               ecc_out_ready,
    input  logic [BEAT_W-1:0]  ecc_out_data,
    input  logic               ecc_out_bad,
    output logic               st_we,
    output logic [SLOT_W-1:0]  st_slot,
    output logic [BEAT_IW-1:0] st_beat,
    output logic [BEAT_W-1:0]  st_wdata,
    input  logic [BEAT_W-1:0]  st_rdata,
    input  logic               buf_lost,
    output logic               busy,
    output logic               prog_err
);

    logic              tag_hit;
    logic [SLOT_W-1:0] tag_hit_slot;
    logic [SLOT_W-1:0] tag_alloc_slot;
    logic              tag_claim;
    logic              tag_set;
    logic              tag_clr;

    lsbc_tag_table #(.SLOTS(SLOTS), .WL_W(WL_W), .SLOT_W(SLOT_W)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .look_wl(cmd_wl), .hit(tag_hit), .hit_slot(tag_hit_slot),
        .alloc_slot(tag_alloc_slot), .claim(tag_claim),
        .set_en(tag_set), .set_slot(st_slot), .set_wl(fl_wl),
        .clr_en(tag_clr), .clr_slot(tag_claim ? tag_alloc_slot : st_slot),
        .flush(buf_lost)
    );

    lsbc_seq #(.WL_W(WL_W), .BEAT_W(BEAT_W), .PAGE_BEATS(PAGE_BEATS),
               .SLOT_W(SLOT_W), .BEAT_IW(BEAT_IW)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_msb(cmd_msb), .cmd_wl(cmd_wl),
        .hd_valid(hd_valid), .hd_ready(hd_ready), .hd_data(hd_data),
        .fl_valid(fl_valid), .fl_ready(fl_ready), .fl_op(fl_op), .fl_wl(fl_wl),
        .fl_data(fl_data), .fl_last(fl_last), .fl_done(fl_done),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .ecc_in_valid(ecc_in_valid), .ecc_in_ready(ecc_in_ready),
        .ecc_in_data(ecc_in_data), .ecc_in_last(ecc_in_last),
        .ecc_out_valid(ecc_out_valid), .ecc_out_ready(ecc_out_ready),
        .ecc_out_data(ecc_out_data), .ecc_out_bad(ecc_out_bad),
        .st_we(st_we), .st_slot(st_slot), .st_beat(st_beat),
        .st_wdata(st_wdata), .st_rdata(st_rdata),
        .busy(busy), .prog_err(prog_err),
        .tag_hit(tag_hit), .tag_hit_slot(tag_hit_slot), .tag_alloc_slot(tag_alloc_slot),
        .tag_claim(tag_claim), .tag_set(tag_set), .tag_clr(tag_clr)
    );

endmodule

// File: tb/lsb_cache_prog_ctrl_test.sv
// Directed bench: flash, correction engine, store and host are modelled here.
module lsb_cache_prog_ctrl_test;

    localparam int PB = 16;
    localparam int SL = 4;
    localparam logic [31:0] XMASK = 32'h0101_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        cmd_valid = 1'b0, cmd_msb = 1'b0;
    logic [7:0]  cmd_wl = '0;
    logic        cmd_ready, hd_ready, hd_valid;
    logic [31:0] hd_data;
    logic        fl_valid, fl_last, fl_done;
    logic        fl_ready;
    logic [2:0]  fl_op;
    logic [7:0]  fl_wl;
    logic [31:0] fl_data;
    logic        rd_valid, rd_ready;
    logic [31:0] rd_data;
    logic        ecc_in_valid, ecc_in_last, ecc_out_valid, ecc_out_ready, ecc_out_bad;
    logic        ecc_in_ready;
    logic [31:0] ecc_in_data, ecc_out_data;
    logic        st_we;
    logic [1:0]  st_slot;
    logic [3:0]  st_beat;
    logic [31:0] st_wdata, st_rdata;
    logic        buf_lost = 1'b0;
    logic        busy, prog_err;

    int n_run = 0, n_fail = 0;
    logic bp_en = 1'b0, bad_mode = 1'b0;

    lsb_cache_prog_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_msb(cmd_msb), .cmd_wl(cmd_wl),
        .hd_valid(hd_valid), .hd_ready(hd_ready), .hd_data(hd_data),
        .fl_valid(fl_valid), .fl_ready(fl_ready), .fl_op(fl_op), .fl_wl(fl_wl),
        .fl_data(fl_data), .fl_last(fl_last), .fl_done(fl_done),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .ecc_in_valid(ecc_in_valid), .ecc_in_ready(ecc_in_ready),
        .ecc_in_data(ecc_in_data), .ecc_in_last(ecc_in_last),
        .ecc_out_valid(ecc_out_valid), .ecc_out_ready(ecc_out_ready),
        .ecc_out_data(ecc_out_data), .ecc_out_bad(ecc_out_bad),
        .st_we(st_we), .st_slot(st_slot), .st_beat(st_beat),
        .st_wdata(st_wdata), .st_rdata(st_rdata),
        .buf_lost(buf_lost), .busy(busy), .prog_err(prog_err)
    );

    function automatic logic [31:0] lpat(input logic [7:0] w, input int b);
        return {8'hA5, w, 16'(b)};
    endfunction
    function automatic logic [31:0] mpat(input logic [7:0] w, input int b);
        return {8'h5C, w, 16'(b)};
    endfunction

    // host: always offers the next beat of the current page
    int hidx = 0;
    assign hd_valid = 1'b1;
    assign hd_data  = cmd_msb ? mpat(cmd_wl, hidx) : lpat(cmd_wl, hidx);
    always @(posedge clk) begin
        if (cmd_valid && cmd_ready) hidx <= 0;
        else if (hd_valid && hd_ready) hidx <= hidx + 1;
    end

    // store model with combinational read
    logic [31:0] smem [SL][PB];
    int last_wr_slot = -1;
    assign st_rdata = smem[st_slot][st_beat];
    always @(posedge clk) if (st_we) begin
        smem[st_slot][st_beat] <= st_wdata;
        last_wr_slot <= int'(st_slot);
    end

    // flash model: logs accepted beats, completes programs, returns raw reads
    logic [2:0]  log_op   [1024];
    logic [31:0] log_data [1024];
    logic [7:0]  log_wl   [1024];
    logic        log_last [1024];
    int log_n = 0, dcnt = 0, rd_idx = 0;
    logic [7:0] rd_wl = '0;
    logic fl_rdy_q = 1'b1;
    assign fl_ready = bp_en ? fl_rdy_q : 1'b1;
    assign rd_data  = lpat(rd_wl, rd_idx) ^ XMASK;
    initial begin fl_done = 1'b0; rd_valid = 1'b0; end
    always @(posedge clk) begin
        fl_rdy_q <= ~fl_rdy_q;
        fl_done  <= 1'b0;
        if (fl_valid && fl_ready) begin
            log_op[log_n] <= fl_op; log_data[log_n] <= fl_data;
            log_wl[log_n] <= fl_wl; log_last[log_n] <= fl_last;
            log_n <= log_n + 1;
            if (fl_op == 3'd2 || fl_op == 3'd3) dcnt <= 3;
            if (fl_op == 3'd4) begin rd_valid <= 1'b1; rd_idx <= 0; rd_wl <= fl_wl; end
        end else if (dcnt != 0) begin
            dcnt <= dcnt - 1;
            if (dcnt == 1) fl_done <= 1'b1;
        end
        if (rd_valid && rd_ready) begin
            if (rd_idx == PB - 1) rd_valid <= 1'b0;
            else rd_idx <= rd_idx + 1;
        end
    end

    // correction engine model: takes a whole page, returns it repaired
    logic [31:0] ebuf [PB];
    int ein = 0, eo_idx = 0, ecc_beats = 0, ecc_lasts = 0;
    assign ecc_in_ready = 1'b1;
    assign ecc_out_data = ebuf[eo_idx] ^ XMASK;
    assign ecc_out_bad  = bad_mode && (eo_idx == PB - 1);
    initial ecc_out_valid = 1'b0;
    always @(posedge clk) begin
        if (ecc_in_valid && ecc_in_ready) begin
            ebuf[ein] <= ecc_in_data;
            ecc_beats <= ecc_beats + 1;
            if (ecc_in_last) begin
                ecc_lasts <= ecc_lasts + 1; ein <= 0;
                ecc_out_valid <= 1'b1; eo_idx <= 0;
            end else ein <= ein + 1;
        end
        if (ecc_out_valid && ecc_out_ready) begin
            if (eo_idx == PB - 1) ecc_out_valid <= 1'b0;
            else eo_idx <= eo_idx + 1;
        end
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // issue one command and wait for it to finish; returns log start index
    task automatic run_cmd(input logic msb, input logic [7:0] wl, output int base);
        @(negedge clk);
        base = log_n;
        cmd_msb = msb; cmd_wl = wl; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
    endtask

    task automatic pulse_lost();
        @(negedge clk); buf_lost = 1'b1;
        @(negedge clk); buf_lost = 1'b0;
    endtask

    // check a load stream of PB beats starting at index s
    task automatic chk_load(input int s, input logic [2:0] op, input logic [7:0] wl,
                            input logic hi, input string req);
        for (int b = 0; b < PB; b++) begin
            logic [31:0] e;
            e = hi ? mpat(wl, b) : lpat(wl, b);
            chk(log_op[s+b] == op && log_data[s+b] == e && log_wl[s+b] == wl
                && log_last[s+b] == (b == PB - 1), req, log_data[s+b], e);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!busy && cmd_ready && !fl_valid && !prog_err, "R1 reset state",
            {busy, cmd_ready, fl_valid, prog_err}, 32'b0100);
    endtask

    task automatic t_lsb();
        int base;
        run_cmd(1'b0, 8'd3, base);
        chk(log_n - base == PB + 1, "R2 op count", log_n - base, PB + 1);
        chk_load(base, 3'd0, 8'd3, 1'b0, "R2 low load beat");
        chk(log_op[base+PB] == 3'd2, "R2 program low", log_op[base+PB], 2);
        chk(smem[0][PB-1] == lpat(8'd3, PB - 1), "R2 store copy", smem[0][PB-1], lpat(8'd3, PB - 1));
        chk(!busy, "R2 busy released", busy, 0);
    endtask

    task automatic t_msb_hit();
        int base;
        bp_en = 1'b1;
        run_cmd(1'b1, 8'd3, base);
        bp_en = 1'b0;
        chk(log_n - base == 2 * PB + 1, "R3 R9 op count under backpressure", log_n - base, 2 * PB + 1);
        chk_load(base, 3'd0, 8'd3, 1'b0, "R3 stored low page");
        chk_load(base + PB, 3'd1, 8'd3, 1'b1, "R3 high page");
        chk(log_op[base+2*PB] == 3'd3, "R3 program high", log_op[base+2*PB], 3);
    endtask

    task automatic t_msb_again();
        int base, eb;
        eb = ecc_beats;
        run_cmd(1'b1, 8'd3, base);
        chk(log_op[base] == 3'd4, "R7 dropped after completion, read issued", log_op[base], 4);
        chk(ecc_beats - eb == PB && ecc_lasts >= 1, "R4 beats to engine", ecc_beats - eb, PB);
        chk(log_n - base == 2 * PB + 2, "R4 op count", log_n - base, 2 * PB + 2);
        chk_load(base + 1, 3'd0, 8'd3, 1'b0, "R4 corrected low page");
        chk(log_op[base+2*PB+1] == 3'd3, "R4 program high", log_op[base+2*PB+1], 3);
    endtask

    task automatic t_lost();
        int base;
        run_cmd(1'b0, 8'd7, base);
        pulse_lost();
        run_cmd(1'b1, 8'd7, base);
        chk(log_op[base] == 3'd4, "R6 miss after loss", log_op[base], 4);
        chk_load(base + 1, 3'd0, 8'd7, 1'b0, "R6 corrected low page");
    endtask

    task automatic t_bad();
        int base;
        run_cmd(1'b0, 8'd9, base);
        pulse_lost();
        bad_mode = 1'b1;
        run_cmd(1'b1, 8'd9, base);
        bad_mode = 1'b0;
        chk(log_n - base == 1 && log_op[base] == 3'd4, "R5 only read issued", log_n - base, 1);
        chk(prog_err && !busy, "R5 error flag", {prog_err, busy}, 32'b10);
        @(negedge clk);
        cmd_msb = 1'b0; cmd_wl = 8'd20; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(!prog_err, "R5 flag cleared by next command", prog_err, 0);
        for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
    endtask

    task automatic t_evict();
        int base;
        pulse_lost();
        run_cmd(1'b0, 8'd10, base);
        chk(last_wr_slot == 0, "R8 lowest free slot", last_wr_slot, 0);
        run_cmd(1'b0, 8'd11, base);
        run_cmd(1'b0, 8'd12, base);
        run_cmd(1'b0, 8'd13, base);
        run_cmd(1'b0, 8'd14, base);
        chk(last_wr_slot == 0, "R8 victim slot 0", last_wr_slot, 0);
        run_cmd(1'b1, 8'd14, base);
        chk(log_op[base] == 3'd0 && log_data[base] == lpat(8'd14, 0), "R8 newest hits",
            log_data[base], lpat(8'd14, 0));
        run_cmd(1'b1, 8'd10, base);
        chk(log_op[base] == 3'd4, "R8 evicted wordline misses", log_op[base], 4);
        run_cmd(1'b1, 8'd11, base);
        chk(log_op[base] == 3'd0, "R8 unevicted wordline hits", log_op[base], 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_lsb();
        t_msb_hit();
        t_msb_again();
        t_lost();
        t_bad();
        t_evict();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule